// File: doc/BRIEF.md
# Synchronous Burst Host Port Slave

This block is the slave side of a 32-bit multiplexed address/data bus. An external host uses it to reach two internal registers: a data register and an address register. The host opens an access with a one-clock strobe. It then moves one or more data beats. The access closes on the beat that carries the burst-last marker. A dedicated select pin, sampled with the strobe, picks which register the whole access targets. The address word on the bus during the strobe is not used for decoding.

Each beat lasts two clocks. In the first clock, ready is driven inactive. In the second, ready is driven active (low), and the beat completes on the edge that ends it. The host must hold write data, byte enables and the burst-last marker through both clocks of a beat. The sampled ready is the block's only back-pressure on the host. Every beat to the data register advances the address register by one word. A back-off input abandons the access at once: the block releases the ready and data drivers in the same cycle and drops the beat in progress.

The sense of the read/write pin and of the burst-last pin is set by two static configuration inputs. The three-state pins are brought out as a value plus an output enable.

Top module: `hp_port`

## Requirements
- R1: After reset the block is idle, both registers hold 0, and neither `hb_rdy_oe` nor `hb_ad_oe` is asserted.
- R2: When `hb_strobe` is high at a rising edge while the block is idle, an access opens. From the next cycle `hb_rdy_oe` is 1. Each beat shows `hb_rdy_n`=1 for one cycle and then `hb_rdy_n`=0 for one cycle. The beat completes on the edge that ends the low cycle.
- R3: `hb_sel` is sampled with the strobe: 0 targets the data register and 1 targets the address register, for the whole access.
- R4: On a write beat, `hb_be[k]`=1 replaces bits 8k+7..8k of the target with the same bits of `hb_ad_i` (k=3 covers 31:24, down to k=0 covering 7:0). Bytes whose enable is 0 keep their value.
- R5: During both cycles of a read beat, `hb_ad_oe` is 1 and `hb_ad_o` carries all 32 bits of the target register, whatever `hb_be` holds. A read beat changes neither register's contents, apart from the step in R8.
- R6: `hb_last` is active when it equals `cfg_last_hi`. A beat that completes with `hb_last` active ends the access, and `hb_rdy_oe` is 0 in the next cycle. Otherwise another beat follows.
- R7: `hb_rw` selects a write when it equals `cfg_wr_hi` at the strobe, and a read otherwise.
- R8: Every completed beat to the data register, read or write, adds 4 to the address register, modulo 2^32.
- R9: While `hb_backoff` is 1 during an access, `hb_rdy_oe` and `hb_ad_oe` are 0 in the same cycle. The access ends at the next edge, the beat in progress commits nothing, and the block stays idle until a new strobe.
- R10: A strobe seen during an open access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_hi | input | 1 | Level of `hb_rw` that means write |
| cfg_last_hi | input | 1 | Active level of `hb_last` |
| hb_strobe | input | 1 | Access start, high for the first clock |
| hb_sel | input | 1 | Register select: 0 data, 1 address |
| hb_rw | input | 1 | Read/write select |
| hb_last | input | 1 | Burst-last marker |
| hb_be | input | 4 | Byte enables, one per data lane |
| hb_backoff | input | 1 | Abandon access and release the bus |
| hb_ad_i | input | 32 | Bus value from the host |
| hb_ad_o | output | 32 | Read data toward the host |
| hb_ad_oe | output | 1 | Drive enable for `hb_ad_o` |
| hb_rdy_n | output | 1 | Active-low ready |
| hb_rdy_oe | output | 1 | Drive enable for `hb_rdy_n` |

## Verification
The assertions take the configuration inputs as steady for the whole of an access. They also take beat data, enables and the burst-last marker as stable across both clocks of a beat, which is the rule R2 places on the host. The stimulus changes inputs only at falling edges. It alters the polarity inputs only while the block is idle, and holds every beat input for its two cycles. Back-off and stray strobes are the only inputs raised mid-access, and both are covered by their own requirements.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READY = 2'd2
  } hp_state_e;
endpackage

// File: rtl/hp_decode.sv
module hp_decode (
  input  logic rw_pin,
  input  logic last_pin,
  input  logic cfg_wr_hi,
  input  logic cfg_last_hi,
  output logic is_wr,
  output logic is_last
);
  // Pin levels are compared against the configured active level.
  assign is_wr   = (rw_pin == cfg_wr_hi);
  assign is_last = (last_pin == cfg_last_hi);
endmodule

// File: rtl/hp_fsm.sv
module hp_fsm
  import hp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe,
  input  logic      backoff,
  input  logic      is_wr,
  input  logic      sel,
  input  logic      is_last,
  output hp_state_e st,
  output logic      busy,
  output logic      beat_done,
  output logic      acc_wr,
  output logic      acc_sel
);
  hp_state_e st_nxt;

  assign busy      = (st != ST_IDLE);
  assign beat_done = (st == ST_READY) && !backoff;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE:  if (strobe) st_nxt = ST_WAIT;
      ST_WAIT:  st_nxt = backoff ? ST_IDLE : ST_READY;
      ST_READY: begin
        if (backoff || is_last) st_nxt = ST_IDLE;
        else                    st_nxt = ST_WAIT;
      end
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      acc_wr  <= 1'b0;
      acc_sel <= 1'b0;
    end else begin
      st <= st_nxt;
      if (st == ST_IDLE && strobe) begin
        acc_wr  <= is_wr;
        acc_sel <= sel;
      end
    end
  end

  // R2: one wait cycle is always followed by the ready cycle
  p_wait_then_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !backoff) |=> (st == ST_READY));

  // R9: back-off closes the access at the next edge
  p_backoff_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && backoff) |=> (st == ST_IDLE));

  // R6: a completed beat marked last closes the access
  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && is_last) |=> (st == ST_IDLE));

  // R10: target and direction stay fixed while an access is open
  p_hold_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (st == ST_IDLE) || ($stable(acc_sel) && $stable(acc_wr)));
endmodule

// File: rtl/hp_regs.sv
module hp_regs #(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat_done,
  input  logic            acc_wr,
  input  logic            acc_sel,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   dat_q,
  output logic [DW-1:0]   adr_q
);
  localparam int unsigned NB   = DW / 8;
  localparam int unsigned STEP = NB;

  logic [DW-1:0] dat_mrg, adr_mrg;
  logic          wr_dat, wr_adr, hit_dat;

  assign wr_dat  = beat_done && acc_wr && !acc_sel;
  assign wr_adr  = beat_done && acc_wr &&  acc_sel;
  assign hit_dat = beat_done && !acc_sel;

  // Per-lane merge of enabled bytes into each register.
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign dat_mrg[b*8 +: 8] = be[b] ? wdata[b*8 +: 8] : dat_q[b*8 +: 8];
    assign adr_mrg[b*8 +: 8] = be[b] ? wdata[b*8 +: 8] : adr_q[b*8 +: 8];

    // R4: a disabled lane keeps its byte on a data-register write
    p_lane_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dat && !be[b]) |=> $stable(dat_q[b*8 +: 8]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      adr_q <= '0;
    end else begin
      if (wr_dat)       dat_q <= dat_mrg;
      if (wr_adr)       adr_q <= adr_mrg;
      else if (hit_dat) adr_q <= adr_q + DW'(STEP);
    end
  end

  // R8: each data-register beat steps the address by one word
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dat |=> (adr_q == $past(adr_q) + DW'(STEP)));

  // R5: a read beat leaves the data register untouched
  p_read_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !acc_wr) |=> $stable(dat_q));
endmodule

// File: rtl/hp_port.sv
module hp_port
  import hp_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_hi,
  input  logic            cfg_last_hi,
  input  logic            hb_strobe,
  input  logic            hb_sel,
  input  logic            hb_rw,
  input  logic            hb_last,
  input  logic [DW/8-1:0] hb_be,
  input  logic            hb_backoff,
  input  logic [DW-1:0]   hb_ad_i,
  output logic [DW-1:0]   hb_ad_o,
  output logic            hb_ad_oe,
  output logic            hb_rdy_n,
  output logic            hb_rdy_oe
);
  hp_state_e     st;
  logic          is_wr, is_last, busy, beat_done, acc_wr, acc_sel;
  logic [DW-1:0] dat_q, adr_q;

  hp_decode u_dec (
    .rw_pin      (hb_rw),
    .last_pin    (hb_last),
    .cfg_wr_hi   (cfg_wr_hi),
    .cfg_last_hi (cfg_last_hi),
    .is_wr       (is_wr),
    .is_last     (is_last)
  );

  hp_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (hb_strobe),
    .backoff   (hb_backoff),
    .is_wr     (is_wr),
    .sel       (hb_sel),
    .is_last   (is_last),
    .st        (st),
    .busy      (busy),
    .beat_done (beat_done),
    .acc_wr    (acc_wr),
    .acc_sel   (acc_sel)
  );

  hp_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_done (beat_done),
    .acc_wr    (acc_wr),
    .acc_sel   (acc_sel),
    .be        (hb_be),
    .wdata     (hb_ad_i),
    .dat_q     (dat_q),
    .adr_q     (adr_q)
  );

  // Drivers release the moment back-off is seen.
  assign hb_rdy_oe = busy && !hb_backoff;
  assign hb_rdy_n  = (st != ST_READY);
  assign hb_ad_oe  = busy && !acc_wr && !hb_backoff;
  assign hb_ad_o   = acc_sel ? adr_q : dat_q;

  // R2: ready is low for a single cycle per beat
  p_rdy_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_rdy_oe && !hb_rdy_n) |=> hb_rdy_n);

  // R5: an address-register read presents a steady word across a beat
  p_read_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_ad_oe && hb_rdy_n && acc_sel && !hb_backoff) |=> $stable(hb_ad_o));
endmodule

// File: tb/sim_hp_port.sv
`timescale 1ns/1ps
module sim_hp_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_hi = 1'b1, cfg_last_hi = 1'b1;
  logic        hb_strobe = 0, hb_sel = 0, hb_rw = 0, hb_last = 0, hb_backoff = 0;
  logic [3:0]  hb_be = 0;
  logic [31:0] hb_ad_i = 0;
  logic [31:0] hb_ad_o;
  logic        hb_ad_oe, hb_rdy_n, hb_rdy_oe;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_dat = 0, m_adr = 0;

  always #2.5 clk = ~clk;

  hp_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_hi(cfg_wr_hi), .cfg_last_hi(cfg_last_hi),
    .hb_strobe(hb_strobe), .hb_sel(hb_sel), .hb_rw(hb_rw), .hb_last(hb_last),
    .hb_be(hb_be), .hb_backoff(hb_backoff), .hb_ad_i(hb_ad_i),
    .hb_ad_o(hb_ad_o), .hb_ad_oe(hb_ad_oe), .hb_rdy_n(hb_rdy_n), .hb_rdy_oe(hb_rdy_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  // One access; bo_beat<0 means no back-off, bo_rdy picks the ready cycle.
  task automatic access(input bit wr, input bit sel, input int len, input logic [3:0] be,
                        input logic [31:0] base, input int bo_beat, input bit bo_rdy,
                        input bit stray);
    logic [31:0] exp, wd;
    @(negedge clk);
    hb_strobe = 1; hb_sel = sel;
    hb_rw = wr ? cfg_wr_hi : !cfg_wr_hi;        // R7
    @(negedge clk);
    hb_strobe = 0; hb_sel = !sel; hb_rw = !hb_rw;
    for (int k = 0; k < len; k++) begin
      wd = base ^ (32'h1111_1111 * k);
      hb_ad_i = wd; hb_be = wr ? be : 4'(k * 5 + 3);
      hb_last = (k == len - 1) ? cfg_last_hi : !cfg_last_hi;
      hb_strobe = stray && (k == 1);
      exp = sel ? m_adr : m_dat;
      if (bo_beat == k && !bo_rdy) begin
        hb_backoff = 1; #1;
        chk("R9 rdy_oe on back-off", 32'(hb_rdy_oe), 0);
        chk("R9 ad_oe on back-off", 32'(hb_ad_oe), 0);
        @(negedge clk); hb_backoff = 0; #1;
        chk("R9 idle after back-off", 32'(hb_rdy_oe), 0);
        return;
      end
      #1;
      chk("R2 wait cycle oe", 32'(hb_rdy_oe), 1);
      chk("R2 wait cycle rdy_n", 32'(hb_rdy_n), 1);
      if (!wr) begin
        chk("R5 ad_oe wait", 32'(hb_ad_oe), 1);
        chk("R3 R5 read data wait", hb_ad_o, exp);
      end
      @(negedge clk);
      hb_strobe = 0;
      if (bo_beat == k) begin
        hb_backoff = 1; #1;
        chk("R9 rdy_oe on back-off", 32'(hb_rdy_oe), 0);
        chk("R9 ad_oe on back-off", 32'(hb_ad_oe), 0);
        @(negedge clk); hb_backoff = 0; #1;
        chk("R9 idle after back-off", 32'(hb_rdy_oe), 0);
        return;
      end
      #1;
      chk("R2 ready cycle rdy_n", 32'(hb_rdy_n), 0);
      if (!wr) chk("R3 R5 read data ready", hb_ad_o, exp);
      if (wr) begin
        if (sel) m_adr = merge(m_adr, wd, be);
        else     m_dat = merge(m_dat, wd, be);
      end
      if (!sel) m_adr = m_adr + 4;               // R8
      @(negedge clk);
    end
    #1;
    chk("R6 access closed after last", 32'(hb_rdy_oe), 0);
    hb_last = !cfg_last_hi;
  endtask

  task automatic read_both();
    access(0, 1, 1, 4'h0, 0, -1, 0, 0);
    access(0, 0, 1, 4'h0, 0, -1, 0, 0);
  endtask

  initial begin
    fork
      begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    #1;
    chk("R1 rdy_oe after reset", 32'(hb_rdy_oe), 0);
    chk("R1 ad_oe after reset", 32'(hb_ad_oe), 0);
    rst_n = 1;
    read_both();                                 // R1 registers reset to 0

    // R4 R6 R7: all enables under every polarity pairing
    for (int pc = 0; pc < 4; pc++) begin
      @(negedge clk);
      cfg_wr_hi = pc[0]; cfg_last_hi = pc[1];
      for (int b = 0; b < 16; b++) begin
        access(1, 0, 1, 4'(b), 32'hA5C3_0000 + 32'(b * 32'h0301_0907) + 32'(pc), -1, 0, 0);
        access(1, 1, 1, 4'(15 - b), 32'h3C5A_7E81 ^ 32'(b << 9), -1, 0, 0);
        read_both();
      end
    end

    // R8: address wraps during a data-register read burst
    access(1, 1, 1, 4'hF, 32'hFFFF_FFF8, -1, 0, 0);
    access(0, 0, 4, 4'h0, 0, -1, 0, 0);
    read_both();

    // R6: bursts of several lengths, both targets
    for (int len = 1; len <= 4; len++) begin
      access(1, 0, len, 4'(len * 3), 32'h0F1E_2D3C * len, -1, 0, 0);
      access(1, 1, len, 4'(16 - len), 32'h7654_3210 + len, -1, 0, 0);
      read_both();
    end

    // R9: back-off at every beat and phase
    for (int bb = 0; bb < 3; bb++)
      for (int ph = 0; ph < 2; ph++) begin
        access(1, 0, 3, 4'hF, 32'hDEAD_0000 + 32'(bb * 16 + ph), bb, ph[0], 0);
        read_both();
        access(0, 1, 3, 4'h0, 0, bb, ph[0], 0);
        read_both();
      end

    // R10: stray strobe inside a burst
    access(1, 0, 3, 4'hF, 32'hC001_D00D, -1, 0, 1);
    access(0, 1, 3, 4'h0, 0, -1, 0, 1);
    read_both();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule